// File: doc/BRIEF.md
# Register-Launched Pitch Rectangle Copier

This block copies a byte rectangle between two row-major memory regions. Software programs it by writing 32-bit words into an indexed method space. It sets two 40-bit base addresses, two row strides, a row length in bytes and a row count. It then writes a control word, and that write starts the copy. The control word chooses between a single contiguous run and a multi-row rectangle. It also declares the memory layout of each side, and it carries several options that this engine does not execute.

For each row, the engine sends two requests to a simple memory port: a read of the source row, then a write of the destination row. Each request carries a byte address, a byte length and a direction flag, and it is held until the port accepts it. A one-cycle `done` pulse marks the end of the copy. A control word that asks for an unsupported option raises `err` and moves no data. A copy with nothing to move finishes at once.

Top module: `pitch_rect_copier`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `mem_req_valid` are all 0.
- R2: Each base address is 40 bits wide. Bits [39:32] come from bits [7:0] of the high word and bits [31:0] from the low word. The source high and low words sit at indices 0x100 and 0x101, the destination words at 0x102 and 0x103. Bits [31:8] of a high word have no effect.
- R3: If control bit 9 is 0 (single-run mode), the copy is one read of `row_len` bytes at the source base, then one write of `row_len` bytes at the destination base. The row count is ignored. `row_len` is at index 0x106.
- R4: If control bit 9 is 1, rows n = 0 to count-1 are moved in increasing order. Row n is a read at src + n·src_stride, then a write at dst + n·dst_stride. The sums are 40 bits wide with carry into the high bits. The strides are at indices 0x104 (source) and 0x105 (destination), and the count is at 0x107.
- R5: While `mem_req_valid` is high and `mem_req_ready` is low, the request's address, length and direction stay unchanged.
- R6: `done` is high for exactly one cycle. It is high in the cycle after the final write is accepted, and `busy` is low in that cycle.
- R7: A write of the control word to index 0xC0 is accepted only if all of the following hold:
  - bits [1:0] = 2;
  - bits [4:3] = 0;
  - bits [6:5] = 0;
  - bit 7 = 1;
  - bit 8 = 1;
  - bit 10 = 0.

  Any other control word sets `err` in the next cycle, issues no request and gives no `done`. The next accepted control word clears `err`.
- R8: An accepted control word with `row_len` = 0, or with multi-row mode and a row count of 0, issues no request. In that case `done` is high in the cycle after the control write.
- R9: A control write while `busy` is high is ignored. The running copy keeps its addresses and ends with a single `done`.
- R10: Writes to any index other than 0xC0 start nothing. This includes 0xC1 and 0x7FF.
- R11: Control bit 2 (flush) has no effect on the requests issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Method write strobe |
| cfg_idx | input | 11 | Method word index |
| cfg_data | input | 32 | Method write data |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last control word was rejected |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_write | output | 1 | 1 = write request, 0 = read request |
| mem_req_addr | output | 40 | Request byte address |
| mem_req_len | output | 32 | Request length in bytes |
| mem_req_ready | input | 1 | Memory port accepts the request |

## Verification
The assertions assume that the memory port never takes back a request it has granted. Under that assumption, a read grant is always followed by a write request.

The assertions also assume that a control write reaches the engine only as a single-cycle strobe. The bench drives every method write as exactly one strobed cycle.

The bench's memory responder raises `mem_req_ready` only while a request is present. It holds back each request for a fixed number of cycles, taken from 0 to 4, so both the held-request path and the back-to-back path are covered.

// File: rtl/prc_pkg.sv
package prc_pkg;

  localparam int IX_CTRL     = 'h0C0;
  localparam int IX_RANGE_LO = 'h100;
  localparam int NUM_CFG     = 8;

  localparam int SLOT_SRC_HI = 0;
  localparam int SLOT_SRC_LO = 1;
  localparam int SLOT_DST_HI = 2;
  localparam int SLOT_DST_LO = 3;
  localparam int SLOT_SSTR   = 4;
  localparam int SLOT_DSTR   = 5;
  localparam int SLOT_LEN    = 6;
  localparam int SLOT_CNT    = 7;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic       remap;
    logic       multi;
    logic       dst_pitch;
    logic       src_pitch;
    logic [1:0] intr;
    logic [1:0] sem;
    logic       flush;
    logic [1:0] xfer;
  } ctrl_t;

  function automatic ctrl_t ctrl_unpack(input logic [10:0] w);
    ctrl_t c;
    c.xfer      = w[1:0];
    c.flush     = w[2];
    c.sem       = w[4:3];
    c.intr      = w[6:5];
    c.src_pitch = w[7];
    c.dst_pitch = w[8];
    c.multi     = w[9];
    c.remap     = w[10];
    return c;
  endfunction

  function automatic logic ctrl_supported(input ctrl_t c);
    return (c.xfer == 2'd2) && (c.sem == 2'd0) && (c.intr == 2'd0) &&
           c.src_pitch && c.dst_pitch && !c.remap;
  endfunction

  function automatic logic [31:0] row_total(input logic multi, input logic [31:0] cnt);
    return multi ? cnt : 32'd1;
  endfunction

endpackage

// File: rtl/prc_regs.sv
module prc_regs
  import prc_pkg::*;
#(
  parameter int IDX_W = 11,
  parameter int DW    = 32,
  parameter int UP_W  = 8,
  localparam int AW   = DW + UP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [DW-1:0]    data,
  output logic             ctrl_hit,
  output logic [AW-1:0]    src_base,
  output logic [AW-1:0]    dst_base,
  output logic [DW-1:0]    src_stride,
  output logic [DW-1:0]    dst_stride,
  output logic [DW-1:0]    row_len,
  output logic [DW-1:0]    row_cnt
);

  logic [DW-1:0] slot [NUM_CFG];

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        slot[g] <= '0;
      else if (we && (idx == IDX_W'(IX_RANGE_LO + g)))
        slot[g] <= data;
    end
  end

  assign ctrl_hit   = we && (idx == IDX_W'(IX_CTRL));
  assign src_base   = {slot[SLOT_SRC_HI][UP_W-1:0], slot[SLOT_SRC_LO]};
  assign dst_base   = {slot[SLOT_DST_HI][UP_W-1:0], slot[SLOT_DST_LO]};
  assign src_stride = slot[SLOT_SSTR];
  assign dst_stride = slot[SLOT_DSTR];
  assign row_len    = slot[SLOT_LEN];
  assign row_cnt    = slot[SLOT_CNT];

endmodule

// File: rtl/prc_ctrl_dec.sv
module prc_ctrl_dec
  import prc_pkg::*;
(
  input  logic [10:0] word,
  output logic        supported,
  output logic        multi
);

  ctrl_t c;

  assign c         = ctrl_unpack(word);
  assign supported = ctrl_supported(c);
  assign multi     = c.multi;

endmodule

// File: rtl/prc_seq.sv
module prc_seq
  import prc_pkg::*;
#(
  parameter int DW   = 32,
  parameter int UP_W = 8,
  localparam int AW  = DW + UP_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_hit,
  input  logic          supported,
  input  logic          multi,
  input  logic [AW-1:0] src_base,
  input  logic [AW-1:0] dst_base,
  input  logic [DW-1:0] src_stride,
  input  logic [DW-1:0] dst_stride,
  input  logic [DW-1:0] row_len,
  input  logic [DW-1:0] row_cnt,
  input  logic          mem_ready,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          req_valid,
  output logic          req_write,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_len,
  output logic          start,
  output logic          wr_accept,
  output logic          last_row
);

  seq_state_e    state;
  logic [AW-1:0] cur_src, cur_dst;
  logic [DW-1:0] str_s, str_d, len_q, left;
  logic [DW-1:0] rows;
  logic          empty;

  assign rows      = row_total(multi, row_cnt);
  assign empty     = (row_len == '0) || (rows == '0);
  assign start     = ctrl_hit && (state == ST_IDLE);
  assign wr_accept = (state == ST_WR) && mem_ready;
  assign last_row  = (left == DW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      done    <= 1'b0;
      err     <= 1'b0;
      cur_src <= '0;
      cur_dst <= '0;
      str_s   <= '0;
      str_d   <= '0;
      len_q   <= '0;
      left    <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            if (!supported) begin
              err <= 1'b1;
            end else begin
              err <= 1'b0;
              if (empty) begin
                done <= 1'b1;
              end else begin
                state   <= ST_RD;
                cur_src <= src_base;
                cur_dst <= dst_base;
                str_s   <= src_stride;
                str_d   <= dst_stride;
                len_q   <= row_len;
                left    <= rows;
              end
            end
          end
        end
        ST_RD: begin
          if (mem_ready) state <= ST_WR;
        end
        ST_WR: begin
          if (mem_ready) begin
            if (last_row) begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end else begin
              state   <= ST_RD;
              left    <= left - DW'(1);
              cur_src <= cur_src + AW'(str_s);
              cur_dst <= cur_dst + AW'(str_d);
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state != ST_IDLE);
  assign req_valid = busy;
  assign req_write = (state == ST_WR);
  assign req_addr  = (state == ST_WR) ? cur_dst : cur_src;
  assign req_len   = len_q;

endmodule

// File: rtl/pitch_rect_copier.sv
module pitch_rect_copier
  import prc_pkg::*;
#(
  parameter int IDX_W = 11,
  parameter int DW    = 32,
  parameter int UP_W  = 8,
  localparam int AW   = DW + UP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [DW-1:0]    cfg_data,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic             mem_req_valid,
  output logic             mem_req_write,
  output logic [AW-1:0]    mem_req_addr,
  output logic [DW-1:0]    mem_req_len,
  input  logic             mem_req_ready
);

  logic          ctrl_hit, supported, multi;
  logic          start, wr_accept, last_row;
  logic [AW-1:0] src_base, dst_base;
  logic [DW-1:0] src_stride, dst_stride, row_len, row_cnt;

  prc_regs #(.IDX_W(IDX_W), .DW(DW), .UP_W(UP_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(cfg_idx), .data(cfg_data),
    .ctrl_hit(ctrl_hit), .src_base(src_base), .dst_base(dst_base),
    .src_stride(src_stride), .dst_stride(dst_stride),
    .row_len(row_len), .row_cnt(row_cnt)
  );

  prc_ctrl_dec u_dec (
    .word(cfg_data[10:0]), .supported(supported), .multi(multi)
  );

  prc_seq #(.DW(DW), .UP_W(UP_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .ctrl_hit(ctrl_hit), .supported(supported),
    .multi(multi), .src_base(src_base), .dst_base(dst_base),
    .src_stride(src_stride), .dst_stride(dst_stride),
    .row_len(row_len), .row_cnt(row_cnt), .mem_ready(mem_req_ready),
    .busy(busy), .done(done), .err(err), .req_valid(mem_req_valid),
    .req_write(mem_req_write), .req_addr(mem_req_addr), .req_len(mem_req_len),
    .start(start), .wr_accept(wr_accept), .last_row(last_row)
  );

endmodule

// File: rtl/prc_chk.sv
module prc_chk #(
  parameter int AW = 40,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic          req_valid,
  input logic          req_write,
  input logic [AW-1:0] req_addr,
  input logic [DW-1:0] req_len,
  input logic          req_ready,
  input logic          ctrl_hit,
  input logic          wr_accept,
  input logic          last_row
);

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) &&
                                   $stable(req_write) && $stable(req_len)));

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_accept && last_row) |=> (done && !busy));

  a_r4_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_ready) |=> (req_valid && req_write));

  a_r7_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy);

  a_r9_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_hit && busy && !wr_accept) |=> (busy && $stable(err)));

endmodule

bind pitch_rect_copier prc_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
  .req_valid(mem_req_valid), .req_write(mem_req_write),
  .req_addr(mem_req_addr), .req_len(mem_req_len), .req_ready(mem_req_ready),
  .ctrl_hit(ctrl_hit), .wr_accept(wr_accept), .last_row(last_row)
);

// File: tb/sim_pitch_rect_copier.sv
module sim_pitch_rect_copier;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [10:0] cfg_idx = '0;
  logic [31:0] cfg_data = '0;
  logic        busy, done, err, mem_req_valid, mem_req_write;
  logic [39:0] mem_req_addr;
  logic [31:0] mem_req_len;
  logic        mem_req_ready = 1'b0;

  always #4 clk = ~clk;

  pitch_rect_copier u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_data(cfg_data), .busy(busy), .done(done), .err(err),
    .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_len(mem_req_len),
    .mem_req_ready(mem_req_ready)
  );

  int nchk = 0;
  int nerr = 0;
  int cyc = 0;

  logic [39:0] la [64];
  logic        lw [64];
  logic [31:0] ll [64];
  int nlog = 0;
  int lat = 0;
  int waitc = 0;
  int done_cnt = 0;
  int done_cyc = 0;
  int last_wr_cyc = 0;
  int launch_cyc = 0;
  bit done_busy = 0;
  bit hold_bad = 0;
  bit prev_wait = 0;
  logic [39:0] prev_addr;
  logic        prev_w;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (done) begin
      done_cnt++;
      done_cyc = cyc;
      done_busy = busy;
    end
    if (prev_wait && (!mem_req_valid || mem_req_addr != prev_addr || mem_req_write != prev_w))
      hold_bad = 1;
    prev_wait = 0;
    if (mem_req_valid) begin
      if (waitc >= lat) begin
        mem_req_ready = 1'b1;
        waitc = 0;
        if (nlog < 64) begin
          la[nlog] = mem_req_addr;
          lw[nlog] = mem_req_write;
          ll[nlog] = mem_req_len;
        end
        nlog++;
        if (mem_req_write) last_wr_cyc = cyc;
      end else begin
        mem_req_ready = 1'b0;
        waitc++;
        prev_wait = 1;
        prev_addr = mem_req_addr;
        prev_w = mem_req_write;
      end
    end else begin
      mem_req_ready = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_idx = 11'(idx);
    cfg_data = d;
    if (idx == 'hC0) launch_cyc = cyc;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setup(input logic [31:0] sh, input logic [31:0] sl,
                       input logic [31:0] dh, input logic [31:0] dl,
                       input logic [31:0] ps, input logic [31:0] pd,
                       input logic [31:0] len, input logic [31:0] cnt);
    wr('h100, sh); wr('h101, sl); wr('h102, dh); wr('h103, dl);
    wr('h104, ps); wr('h105, pd); wr('h106, len); wr('h107, cnt);
    nlog = 0; done_cnt = 0; hold_bad = 0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 400 && done_cnt == 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // expected sequence computed from base + n*stride on 40 bits
  task automatic expect_seq(input string req, input logic [31:0] sh, input logic [31:0] sl,
                            input logic [31:0] dh, input logic [31:0] dl,
                            input logic [31:0] ps, input logic [31:0] pd,
                            input logic [31:0] len, input int rows);
    longint sb, db;
    int nexp;
    sb = (longint'(sh[7:0]) << 32) | longint'(sl);
    db = (longint'(dh[7:0]) << 32) | longint'(dl);
    nexp = (len == 0 || rows == 0) ? 0 : 2 * rows;
    chk(nlog == nexp, req, "request count", nlog, nexp);
    chk(done_cnt == 1, "R6", "done pulses", done_cnt, 1);
    chk(!hold_bad, "R5", "held request changed", hold_bad, 0);
    chk(err == 1'b0, "R7", "err after good launch", err, 0);
    if (nexp == 0) begin
      chk(done_cyc == launch_cyc + 1, "R8", "empty done cycle", done_cyc, launch_cyc + 1);
    end else begin
      chk(done_cyc == last_wr_cyc + 1, "R6", "done cycle", done_cyc, last_wr_cyc + 1);
      chk(!done_busy, "R6", "busy at done", done_busy, 0);
      for (int n = 0; n < rows && 2 * n + 1 < 64; n++) begin
        longint ea, eb;
        ea = (sb + longint'(n) * longint'(ps)) & 40'hFF_FFFF_FFFF;
        eb = (db + longint'(n) * longint'(pd)) & 40'hFF_FFFF_FFFF;
        chk(la[2*n] == 40'(ea) && !lw[2*n] && ll[2*n] == len, req, "read req", la[2*n], ea);
        chk(la[2*n+1] == 40'(eb) && lw[2*n+1] && ll[2*n+1] == len, req, "write req", la[2*n+1], eb);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !err && !mem_req_valid, "R1", "reset outputs",
        {busy, done, err, mem_req_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // sweep: mode, row count, length, latency, flush (R2 R3 R4 R8 R11)
    for (int m = 0; m < 2; m++)
      for (int c = 0; c < 4; c++)
        for (int li = 0; li < 3; li++)
          for (int l = 0; l < 3; l++) begin
            logic [31:0] len, ps, pd, sh, sl, dh, dl, word;
            int rows;
            len = (li == 0) ? 0 : (li == 1) ? 3 : 64;
            ps = 32'h40 + 32'(c * 8 + l);
            pd = 32'h7F0 + 32'(m * 16);
            sh = 32'hABCD_EF12;
            sl = 32'hFFFF_FFC0 + 32'(l * 4);
            dh = 32'h0000_0105;
            dl = 32'h0001_0000 + 32'(c);
            word = 32'h182 | (32'(m) << 9) | (32'(l & 1) << 2);
            lat = l;
            rows = (m == 1) ? c : 1;
            setup(sh, sl, dh, dl, ps, pd, len, 32'(c));
            wr('hC0, word);
            wait_done();
            expect_seq(m ? "R4" : "R3", sh, sl, dh, dl, ps, pd, len, rows);
          end

    // R7 rejected control words
    begin
      logic [31:0] bad [8];
      bad[0] = 32'h380; bad[1] = 32'h381; bad[2] = 32'h383; bad[3] = 32'h38A;
      bad[4] = 32'h3A2; bad[5] = 32'h302; bad[6] = 32'h282; bad[7] = 32'h782;
      for (int b = 0; b < 8; b++) begin
        lat = 0;
        setup(0, 32'h1000, 0, 32'h2000, 16, 16, 8, 2);
        wr('hC0, bad[b]);
        repeat (6) @(negedge clk);
        chk(err == 1'b1, "R7", "err on bad word", err, 1);
        chk(nlog == 0 && done_cnt == 0, "R7", "no traffic on bad word", nlog, 0);
      end
      setup(0, 32'h1000, 0, 32'h2000, 16, 16, 8, 2);
      wr('hC0, 32'h382);
      wait_done();
      expect_seq("R7", 0, 32'h1000, 0, 32'h2000, 16, 16, 8, 2);
    end

    // R9 launch while busy ignored
    lat = 4;
    setup(0, 32'h4000, 0, 32'h8000, 32, 48, 12, 3);
    wr('hC0, 32'h382);
    repeat (2) @(negedge clk);
    chk(busy == 1'b1, "R9", "busy during copy", busy, 1);
    wr('hC0, 32'h182);
    wr('hC0, 32'h000);
    wait_done();
    expect_seq("R9", 0, 32'h4000, 0, 32'h8000, 32, 48, 12, 3);

    // R10 writes elsewhere start nothing
    lat = 0;
    setup(0, 32'h100, 0, 32'h200, 4, 4, 4, 1);
    wr('hC1, 32'h382);
    wr('h7FF, 32'h382);
    wr('h0BF, 32'h382);
    repeat (5) @(negedge clk);
    chk(nlog == 0 && !busy && done_cnt == 0, "R10", "no start from other index",
        nlog, 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule